// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the value of a free-running 16-bit timer count when a chosen event happens. The event comes from one of two places. The first is an external capture pin. The second is a status flag from an on-chip voltage comparator. A select input picks the source, and a polarity input picks whether a rising or a falling transition is the active edge.

Each source passes through its own synchroniser and has its own edge detector. The select and polarity inputs only choose among the detected edges, so changing either one cannot create an edge by itself. On an active edge the block copies the count into a capture register and sets a capture flag. An interrupt request is raised while the flag is set and the interrupt is enabled. Software reads the capture register one byte at a time using separate high and low read strobes. It clears the flag with a strobe.

Two captures taken on edges of the same polarity measure the period of the signal. Two captures taken on edges of opposite polarity measure the pulse width.

Top module: `icap_unit`

## Requirements
- R1: After reset, `cap_flag_o`, `irq_o` and `rd_data_o` are 0, and the capture register holds 0.
- R2: With `src_cmp_i`=0 (pin source) and `pol_rise_i`=1, a 0-to-1 change on `cap_pin_i` sets `cap_flag_o` on the third rising clock edge after the change. The capture register then holds the `count_i` value present on that edge, which is the count seen at the change plus 2.
- R3: With the pin source and `pol_rise_i`=0, only 1-to-0 changes of `cap_pin_i` capture. 0-to-1 changes leave the flag and the capture register unchanged.
- R4: With `src_cmp_i`=1, a 0-to-1 change of `cmp_flag_i` captures with the same latency as R2. With `src_cmp_i`=1 and `pol_rise_i`=0, no transition of `cmp_flag_i` ever captures.
- R5: Transitions on the source that is not selected never capture.
- R6: `cap_flag_o` stays at 1 until `flag_clr_i` is high on a rising edge, and goes to 0 on that edge. If a capture happens on the same edge as the clear, the flag stays at 1.
- R7: `irq_o` equals `cap_flag_o` AND `irq_en_i`, updated on the same edge as the flag.
- R8: On the edge after `rd_hi_i`=1, `rd_data_o` shows capture bits 15:8. On the edge after `rd_lo_i`=1 with `rd_hi_i`=0, it shows bits 7:0. With neither strobe high, `rd_data_o` holds its value.
- R9: Changing `src_cmp_i` or `pol_rise_i` while the source levels stay still causes no capture.
- R10: The difference between two same-polarity captures equals the signal period in clocks. The difference between a rising-edge capture and the next falling-edge capture equals the high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| count_i | input | 16 | Free-running timer count |
| cap_pin_i | input | 1 | External capture pin (asynchronous) |
| cmp_flag_i | input | 1 | Comparator status flag |
| src_cmp_i | input | 1 | Source select: 0 = pin, 1 = comparator |
| pol_rise_i | input | 1 | Edge polarity: 1 = rising, 0 = falling |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Capture flag clear strobe |
| rd_hi_i | input | 1 | Read strobe for the high byte |
| rd_lo_i | input | 1 | Read strobe for the low byte |
| cap_flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Interrupt request |
| rd_data_o | output | 8 | Registered read data byte |

## Verification
A source change is due to show up in the flag, the IRQ and the capture register on the third rising edge after it. The bench therefore checks that the flag is still low after two edges and high after three. The captured value is expected to be the count at the change plus two.

Read data and flag clears take effect one edge after their strobe. Every sample is taken on the falling edge that follows the edge where the result is due.

Period and pulse width are measured from count snapshots that the bench takes when it drives each transition. Both are compared with the difference between two read-back captures.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_CMP = 1'b1
  } icap_src_e;

  localparam int unsigned N_SRC = 2;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/icap_edge.sv
module icap_edge
  import icap_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pin_i,
  input  logic      cmp_i,
  input  icap_src_e src_i,
  input  logic      pol_rise_i,
  output logic      hit_o
);
  logic [N_SRC-1:0] raw, syn, prev_q, rise, fall;

  assign raw = {cmp_i, pin_i};

  // Both sources get equal-depth synchronisers so their latencies match.
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (raw[g]),
      .q_o (syn[g])
    );
  end

  // Each source keeps its own history, so select/polarity changes cannot fake an edge.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= syn;
  end

  assign rise = syn & ~prev_q;
  assign fall = ~syn & prev_q;

  always_comb begin
    unique case (src_i)
      SRC_PIN: hit_o = pol_rise_i ? rise[0] : fall[0];
      SRC_CMP: hit_o = pol_rise_i & rise[1];
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/icap_store.sv
module icap_store #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_i,
  input  logic             hit_i,
  input  logic             clr_i,
  input  logic             irq_en_i,
  input  logic             rd_hi_i,
  input  logic             rd_lo_i,
  output logic             flag_o,
  output logic             irq_o,
  output logic [CNT_W/2-1:0] rd_data_o
);
  localparam int unsigned BYTE_W = CNT_W / 2;

  logic [CNT_W-1:0]  cap_q;
  logic              flag_q, irq_q, flag_nxt;
  logic [BYTE_W-1:0] rd_q;

  // A capture on the clear cycle wins.
  assign flag_nxt = hit_i | (flag_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (hit_i) cap_q <= count_i;
      flag_q <= flag_nxt;
      irq_q  <= flag_nxt & irq_en_i;
      if (rd_hi_i)      rd_q <= cap_q[CNT_W-1:BYTE_W];
      else if (rd_lo_i) rd_q <= cap_q[BYTE_W-1:0];
    end
  end

  assign flag_o    = flag_q;
  assign irq_o     = irq_q;
  assign rd_data_o = rd_q;

  AST_SET_FLAG: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> flag_q); // R6
  AST_CLR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !hit_i) |=> !flag_q); // R6
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hit_i |=> $stable(cap_q)); // R2
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q); // R7
  AST_RD_HIGH: assert property (@(posedge clk) disable iff (rst)
    rd_hi_i |=> rd_q == $past(cap_q[CNT_W-1:BYTE_W])); // R8
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!rd_hi_i && !rd_lo_i) |=> $stable(rd_q)); // R8
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   count_i,
  input  logic               cap_pin_i,
  input  logic               cmp_flag_i,
  input  logic               src_cmp_i,
  input  logic               pol_rise_i,
  input  logic               irq_en_i,
  input  logic               flag_clr_i,
  input  logic               rd_hi_i,
  input  logic               rd_lo_i,
  output logic               cap_flag_o,
  output logic               irq_o,
  output logic [CNT_W/2-1:0] rd_data_o
);
  logic hit;

  icap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .pin_i      (cap_pin_i),
    .cmp_i      (cmp_flag_i),
    .src_i      (icap_src_e'(src_cmp_i)),
    .pol_rise_i (pol_rise_i),
    .hit_o      (hit)
  );

  icap_store #(.CNT_W(CNT_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .count_i   (count_i),
    .hit_i     (hit),
    .clr_i     (flag_clr_i),
    .irq_en_i  (irq_en_i),
    .rd_hi_i   (rd_hi_i),
    .rd_lo_i   (rd_lo_i),
    .flag_o    (cap_flag_o),
    .irq_o     (irq_o),
    .rd_data_o (rd_data_o)
  );

  AST_CMP_FALL_MUTE: assert property (@(posedge clk) disable iff (rst)
    (src_cmp_i && !pol_rise_i && !cap_flag_o) |=> !cap_flag_o); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !irq_en_i |=> !irq_o); // R7
endmodule

// File: tb/tb_icap_unit.sv
module tb_icap_unit;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned NVEC  = 8;
  localparam int unsigned WDOG  = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W-1:0] cnt;
  logic pin = 1'b0, cmp = 1'b0, src = 1'b0, pol = 1'b1, ien = 1'b1;
  logic clr = 1'b0, rdh = 1'b0, rdl = 1'b0;
  logic flag, irq;
  logic [7:0] rdat;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  icap_unit dut (
    .clk(clk), .rst(rst), .count_i(cnt), .cap_pin_i(pin), .cmp_flag_i(cmp),
    .src_cmp_i(src), .pol_rise_i(pol), .irq_en_i(ien), .flag_clr_i(clr),
    .rd_hi_i(rdh), .rd_lo_i(rdl), .cap_flag_o(flag), .irq_o(irq), .rd_data_o(rdat)
  );

  // Vector: {src_cmp, pol_rise, new_level, expect_capture}
  localparam logic [3:0] VEC [NVEC] = '{
    4'b0_1_1_1,  // R2 pin rising captures
    4'b0_1_0_0,  // R3 falling ignored under rising polarity
    4'b0_0_1_0,  // R3 rising ignored under falling polarity
    4'b0_0_0_1,  // R3 pin falling captures
    4'b1_1_1_1,  // R4 comparator rising captures
    4'b1_1_0_0,  // R4 comparator falling ignored
    4'b1_0_1_0,  // R4 comparator with falling polarity muted
    4'b1_0_0_0   // R4 comparator with falling polarity muted
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic read_cap(output logic [15:0] v);
    rdh = 1'b1; tick(1); rdh = 1'b0; v[15:8] = rdat;
    rdl = 1'b1; tick(1); rdl = 1'b0; v[7:0] = rdat;
  endtask

  task automatic clear_flag;
    clr = 1'b1; tick(1); clr = 1'b0;
  endtask

  // Drive a level on the selected source and capture, returning count snapshot.
  task automatic edge_cap(input logic lvl, output logic [15:0] c0, output logic [15:0] v);
    c0 = cnt;
    if (src) cmp = lvl; else pin = lvl;
    tick(3);
    chk(flag === 1'b1, "R10 capture flag", int'(flag), 1);
    read_cap(v);
    clear_flag();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] c0, v, c1, v1, c2, v2;
    tick(3);
    // R1 reset state
    chk(flag === 1'b0, "R1 flag", int'(flag), 0);
    chk(irq === 1'b0, "R1 irq", int'(irq), 0);
    chk(rdat === 8'h00, "R1 rd_data", int'(rdat), 0);
    rst = 1'b0;
    tick(2);
    read_cap(v);
    chk(v === 16'h0000, "R1 capture reg", int'(v), 0);

    for (int k = 0; k < NVEC; k++) begin
      // R9: change config with sources still, then wait: no capture
      src = VEC[k][3]; pol = VEC[k][2];
      tick(4);
      chk(flag === 1'b0, "R9 config change", int'(flag), 0);
      c0 = cnt;
      if (src) cmp = VEC[k][1]; else pin = VEC[k][1];
      tick(2);
      chk(flag === 1'b0, "R2 not before third edge", int'(flag), 0);
      tick(1);
      chk(flag === VEC[k][0], $sformatf("R2/R3/R4 vector %0d flag", k), int'(flag), int'(VEC[k][0]));
      chk(irq === VEC[k][0], $sformatf("R7 vector %0d irq", k), int'(irq), int'(VEC[k][0]));
      if (VEC[k][0]) begin
        read_cap(v);
        chk(v === c0 + 16'd2, $sformatf("R2 vector %0d value", k), int'(v), int'(c0 + 16'd2));
        clear_flag();
        chk(flag === 1'b0, "R6 clear", int'(flag), 0);
      end
    end

    // R5: pin selected, comparator toggles; then comparator selected, pin toggles
    src = 1'b0; pol = 1'b1; tick(4);
    cmp = 1'b1; tick(4); cmp = 1'b0; tick(4);
    chk(flag === 1'b0, "R5 comparator ignored", int'(flag), 0);
    src = 1'b1; tick(4);
    pin = 1'b1; tick(4); pin = 1'b0; tick(4);
    chk(flag === 1'b0, "R5 pin ignored", int'(flag), 0);

    // R7: enable low masks irq while flag is set
    src = 1'b0; ien = 1'b0; tick(2);
    pin = 1'b1; tick(3);
    chk(flag === 1'b1 && irq === 1'b0, "R7 masked irq", int'(irq), 0);
    ien = 1'b1; tick(1);
    chk(irq === 1'b1, "R7 irq follows enable", int'(irq), 1);
    // R6: flag persists without clear
    tick(5);
    chk(flag === 1'b1, "R6 flag holds", int'(flag), 1);
    // R6: clear on the capture edge keeps flag
    pin = 1'b0; pol = 1'b0; tick(2);
    clr = 1'b1; tick(1); clr = 1'b0;
    chk(flag === 1'b1, "R6 set beats clear", int'(flag), 1);
    clear_flag();
    chk(flag === 1'b0, "R6 cleared", int'(flag), 0);
    // R8: no strobe holds rd_data
    v[7:0] = rdat; tick(3);
    chk(rdat === v[7:0], "R8 rd hold", int'(rdat), int'(v[7:0]));

    // R10: period (rising to rising) and high time (rising to falling)
    pol = 1'b1; tick(4);
    edge_cap(1'b1, c1, v1);
    tick(3); pin = 1'b0; tick(6);
    edge_cap(1'b1, c2, v2);
    chk(v2 - v1 === c2 - c1, "R10 period", int'(v2 - v1), int'(c2 - c1));
    pin = 1'b0; tick(6);
    edge_cap(1'b1, c1, v1);
    pol = 1'b0; tick(7);
    edge_cap(1'b0, c2, v2);
    chk(v2 - v1 === c2 - c1, "R10 high time", int'(v2 - v1), int'(c2 - c1));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule